// File: doc/BRIEF.md
# Three-Way Instruction Dispatch Queue

This block buffers fixed-width 32-bit instruction words coming from the fetch side and hands them to three execution units: branch, integer and floating point. Storage is an eight-slot queue that is always packed at its head, with slot 0 the oldest. In one cycle the fetch side can offer up to eight words, and the queue takes as many of them as it has room for.

Only the four oldest slots may dispatch. From that window, each unit receives the oldest instruction of its own class, so at most three instructions leave per cycle. Within a class, instructions always leave in program order. The entries that remain close up toward the head without changing their order, and the newly accepted words join behind them. Each instruction's class comes from a short lookup on its top six bits.

Both edges follow a valid/ready discipline. On the fill side, `fill_cnt` says how many lanes hold valid words, and `fill_acc` reports, in the same cycle, how many of those lanes were taken. The fetch side must offer again any words that were not taken. On the unit side, a unit's valid output does not depend on its ready input. An instruction leaves only in a cycle where both are high. While a unit holds ready low, its candidate stays at the same place in the queue and stays offered. A flush empties the queue and blocks all movement for that cycle.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty: all three unit valid outputs are low, and `fill_acc` equals the offered count, clamped to 8.
- R2: The top six bits [31:26] select the class. Values 16, 18 and 19 mean branch. Values 59 and 63 mean floating point. Every other value means integer.
- R3: Only the four oldest queue slots are candidates. An instruction in slot 4 or later is never offered, even when its unit is idle.
- R4: For each class, the unit valid output is high exactly when that class has an instruction in the window. The unit's instruction output carries the oldest such instruction. It leaves the queue only when the unit's ready input is also high. At most one instruction goes to each unit per cycle.
- R5: An instruction never leaves ahead of an older instruction of its own class that is still queued. This holds in particular for integer instructions.
- R6: `fill_acc` equals the smaller of `fill_cnt` (clamped to 8) and the number of free slots at the start of the cycle. It is 0 during a flush.
- R7: In the cycle after dispatch, the surviving entries sit at the head in their original order, and the accepted words follow them.
- R8: While `flush` is high, no unit valid is asserted and nothing is accepted. In the next cycle the queue is empty.
- R9: Fill lane k sits in bits [32k+31:32k], and lane 0 is the oldest. Accepted lanes are lanes 0 up to `fill_acc`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear the whole queue |
| fill_cnt | input | 4 | Number of valid fill lanes offered |
| fill_words | input | 256 | Eight fill lanes, 32 bits each |
| fill_acc | output | 4 | Number of lanes accepted this cycle |
| br_valid | output | 1 | Branch candidate present |
| br_ready | input | 1 | Branch unit can take an instruction |
| br_instr | output | 32 | Branch candidate word |
| int_valid | output | 1 | Integer candidate present |
| int_ready | input | 1 | Integer unit can take an instruction |
| int_instr | output | 32 | Integer candidate word |
| fp_valid | output | 1 | Floating-point candidate present |
| fp_ready | input | 1 | Floating-point unit can take an instruction |
| fp_instr | output | 32 | Floating-point candidate word |

## Verification
`fill_acc` and the three valid/instruction outputs are combinational functions of the current queue contents and the inputs of the same cycle. The bench therefore drives at the falling edge and compares one time unit later, before the rising edge. Filling, dispatch removal and compaction take effect at the next rising edge. The bench advances its own queue model at that edge, so a word accepted in cycle t is first expected on a unit output in cycle t+1. A flush is checked twice: for a quiet output in its own cycle, and for an empty queue in the following one.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IW   = 32;
  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CLS_BR  = 2'd0,
    CLS_INT = 2'd1,
    CLS_FP  = 2'd2
  } cls_t;

  function automatic cls_t op_class(input logic [5:0] op);
    cls_t r;
    case (op)
      6'd16, 6'd18, 6'd19: r = CLS_BR;
      6'd59, 6'd63:        r = CLS_FP;
      default:             r = CLS_INT;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/iq_classify.sv
module iq_classify
  import iq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0][IW-1:0] words,
  output cls_t [DEPTH-1:0]         cls
);
  // R2: class per slot from the top opcode bits
  for (genvar j = 0; j < DEPTH; j++) begin : g_dec
    assign cls[j] = op_class(words[j][IW-1:IW-6]);
  end
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIN   = 4,
  localparam int IXW  = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [DEPTH-1:0]           q_valid,
  input  cls_t [DEPTH-1:0]           cls,
  input  logic [NCLS-1:0]            unit_rdy,
  output logic [NCLS-1:0]            pick_vld,
  output logic [NCLS-1:0][IXW-1:0]   pick_idx,
  output logic [DEPTH-1:0]           issue_mask
);
  // R3/R4/R5: per class, the oldest matching slot inside the window
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic           found;
    logic [IXW-1:0] idx;
    always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int j = WIN - 1; j >= 0; j--) begin
        if (q_valid[j] && cls[j] == cls_t'(c)) begin
          found = 1'b1;
          idx   = IXW'(j);
        end
      end
    end
    assign pick_vld[c] = found & ~flush;
    assign pick_idx[c] = idx;
  end

  always_comb begin
    issue_mask = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (pick_vld[c] && unit_rdy[c]) issue_mask[pick_idx[c]] = 1'b1;
    end
  end

  a_r4_at_most_three: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue_mask) <= NCLS);
  a_r4_only_live_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & ~q_valid) == '0);
  a_r8_no_issue_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> issue_mask == '0);
endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int FILL_W = 8,
  localparam int CW    = $clog2(FILL_W + 1),
  localparam int OW    = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [CW-1:0]               fill_cnt,
  input  logic [FILL_W-1:0][IW-1:0]   fill_words,
  input  logic [DEPTH-1:0]            issue_mask,
  output logic [DEPTH-1:0][IW-1:0]    q_words,
  output logic [DEPTH-1:0]            q_valid,
  output logic [CW-1:0]               fill_acc
);
  logic [OW-1:0]              occ;
  logic [OW-1:0]              nxt_occ;
  logic [DEPTH-1:0][IW-1:0]   nxt_words;
  int                         acc_i;

  for (genvar j = 0; j < DEPTH; j++) begin : g_vld
    assign q_valid[j] = (j < int'(occ));
  end

  // R6: acceptance bounded by offer and free space at cycle start
  always_comb begin
    int free_i;
    int req_i;
    free_i = DEPTH - int'(occ);
    req_i  = int'(fill_cnt);
    if (req_i > FILL_W) req_i = FILL_W;
    if (flush)               acc_i = 0;
    else if (req_i < free_i) acc_i = req_i;
    else                     acc_i = free_i;
  end
  assign fill_acc = CW'(acc_i);

  // R7/R9: close gaps keeping order, then append accepted lanes
  always_comb begin
    int pos;
    nxt_words = q_words;
    pos = 0;
    for (int j = 0; j < DEPTH; j++) begin
      if (q_valid[j] && !issue_mask[j]) begin
        nxt_words[pos] = q_words[j];
        pos = pos + 1;
      end
    end
    for (int k = 0; k < FILL_W; k++) begin
      if (k < acc_i && pos + k < DEPTH) nxt_words[pos + k] = fill_words[k];
    end
    nxt_occ = flush ? '0 : OW'(pos + acc_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ     <= '0;
      q_words <= '0;
    end else begin
      occ     <= nxt_occ;
      q_words <= nxt_words;
    end
  end

  a_r6_never_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);
  a_r6_acc_fits: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_acc) + int'(occ) <= DEPTH);
  a_r8_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> occ == '0);
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
  import iq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIN    = 4,
  parameter int FILL_W = 8,
  localparam int CW    = $clog2(FILL_W + 1),
  localparam int IXW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [CW-1:0]         fill_cnt,
  input  logic [FILL_W*IW-1:0]  fill_words,
  output logic [CW-1:0]         fill_acc,
  output logic                  br_valid,
  input  logic                  br_ready,
  output logic [IW-1:0]         br_instr,
  output logic                  int_valid,
  input  logic                  int_ready,
  output logic [IW-1:0]         int_instr,
  output logic                  fp_valid,
  input  logic                  fp_ready,
  output logic [IW-1:0]         fp_instr
);
  logic [DEPTH-1:0][IW-1:0]  q_words;
  logic [DEPTH-1:0]          q_valid;
  cls_t [DEPTH-1:0]          cls;
  logic [NCLS-1:0]           unit_rdy;
  logic [NCLS-1:0]           pick_vld;
  logic [NCLS-1:0][IXW-1:0]  pick_idx;
  logic [DEPTH-1:0]          issue_mask;
  logic [FILL_W-1:0][IW-1:0] lanes;

  assign lanes    = fill_words;
  assign unit_rdy = {fp_ready, int_ready, br_ready};

  iq_store #(.DEPTH(DEPTH), .FILL_W(FILL_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_cnt(fill_cnt), .fill_words(lanes), .issue_mask(issue_mask),
    .q_words(q_words), .q_valid(q_valid), .fill_acc(fill_acc)
  );

  iq_classify #(.DEPTH(DEPTH)) classify_i (
    .words(q_words), .cls(cls)
  );

  iq_select #(.DEPTH(DEPTH), .WIN(WIN)) select_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .q_valid(q_valid), .cls(cls), .unit_rdy(unit_rdy),
    .pick_vld(pick_vld), .pick_idx(pick_idx), .issue_mask(issue_mask)
  );

  assign br_valid  = pick_vld[CLS_BR];
  assign int_valid = pick_vld[CLS_INT];
  assign fp_valid  = pick_vld[CLS_FP];
  assign br_instr  = q_words[pick_idx[CLS_BR]];
  assign int_instr = q_words[pick_idx[CLS_INT]];
  assign fp_instr  = q_words[pick_idx[CLS_FP]];

  a_r8_quiet_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!br_valid && !int_valid && !fp_valid && fill_acc == '0));
  a_r2_branch_class: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (br_instr[31:26] == 6'd16 || br_instr[31:26] == 6'd18 ||
                  br_instr[31:26] == 6'd19));
  a_r2_fp_class: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> (fp_instr[31:26] == 6'd59 || fp_instr[31:26] == 6'd63));
  a_r4_held_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ready && !flush) |=> (int_valid || flush));
endmodule

// File: tb/iq_dispatch_tb_top.sv
`timescale 1ns/1ps
module iq_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [3:0]   fill_cnt = '0;
  logic [255:0] fill_words = '0;
  logic [3:0]   fill_acc;
  logic         br_valid, int_valid, fp_valid;
  logic         br_ready = 1'b0, int_ready = 1'b0, fp_ready = 1'b0;
  logic [31:0]  br_instr, int_instr, fp_instr;

  always #2.5 clk = ~clk;

  iq_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fill_cnt(fill_cnt), .fill_words(fill_words), .fill_acc(fill_acc),
    .br_valid(br_valid), .br_ready(br_ready), .br_instr(br_instr),
    .int_valid(int_valid), .int_ready(int_ready), .int_instr(int_instr),
    .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_instr(fp_instr)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] mq [0:15];
  int msz = 0;
  logic [31:0] lw [0:7];

  function automatic int cls_of(logic [31:0] w);
    int op;
    op = int'(w[31:26]);
    if (op == 16 || op == 18 || op == 19) return 0;
    if (op == 59 || op == 63) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] mk(int op);
    return {op[5:0], 26'($urandom)};
  endfunction

  function automatic logic [31:0] gen_word();
    int s;
    int others [4] = '{31, 14, 32, 0};
    int sp [5] = '{16, 18, 19, 59, 63};
    s = int'($urandom % 9);
    if (s < 5) return mk(sp[s]);
    return mk(others[s - 5]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, compare before posedge, advance model at posedge
  task automatic step(int cnt, logic [2:0] rdy, logic fl, string tag);
    int win, idx [3], acc, req, kept;
    logic [31:0] nq [0:15];
    logic [2:0] v;
    logic [31:0] got_i [3];
    logic got_v [3];
    @(negedge clk);
    fill_cnt = 4'(cnt);
    for (int k = 0; k < 8; k++) fill_words[k*32 +: 32] = lw[k];
    {fp_ready, int_ready, br_ready} = rdy;
    flush = fl;
    #1;
    win = (msz < 4) ? msz : 4;
    for (int c = 0; c < 3; c++) begin
      idx[c] = -1;
      for (int j = win - 1; j >= 0; j--) if (cls_of(mq[j]) == c) idx[c] = j;
      v[c] = (idx[c] >= 0) && !fl;
    end
    got_v[0] = br_valid;  got_v[1] = int_valid;  got_v[2] = fp_valid;
    got_i[0] = br_instr;  got_i[1] = int_instr;  got_i[2] = fp_instr;
    for (int c = 0; c < 3; c++) begin
      chk(tag, 32'(got_v[c]), 32'(v[c]));
      if (v[c]) chk(tag, got_i[c], mq[idx[c]]);
    end
    req = (cnt > 8) ? 8 : cnt;
    acc = fl ? 0 : ((req < 8 - msz) ? req : 8 - msz);
    chk("R6", 32'(fill_acc), 32'(acc));
    @(posedge clk);
    if (fl) msz = 0;
    else begin
      kept = 0;
      for (int j = 0; j < msz; j++) begin
        bit gone;
        gone = 0;
        for (int c = 0; c < 3; c++) if (v[c] && rdy[c] && idx[c] == j) gone = 1;
        if (!gone) begin nq[kept] = mq[j]; kept++; end
      end
      for (int k = 0; k < acc; k++) nq[kept + k] = lw[k];
      msz = kept + acc;
      for (int j = 0; j < msz; j++) mq[j] = nq[j];
    end
  endtask

  task automatic rand_lanes();
    for (int k = 0; k < 8; k++) lw[k] = gen_word();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) lw[k] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, full acceptance offered
    lw[0] = mk(14);
    step(0, 3'b000, 0, "R1");
    step(11, 3'b000, 1, "R1");

    // R2: each opcode alone routes to its unit
    begin
      int ops [8] = '{16, 18, 19, 59, 63, 0, 31, 62};
      for (int i = 0; i < 8; i++) begin
        lw[0] = mk(ops[i]);
        step(1, 3'b000, 0, "R2");
        step(0, 3'b000, 0, "R2");
        step(0, 3'b000, 1, "R2");
      end
    end

    // R3: branch at slot 4 is not offered while integers block
    for (int k = 0; k < 4; k++) lw[k] = mk(31);
    lw[4] = mk(18);
    step(5, 3'b000, 0, "R3");
    step(0, 3'b001, 0, "R3");
    step(0, 3'b010, 0, "R3");
    step(0, 3'b001, 0, "R3");
    step(0, 3'b000, 1, "R3");

    // R5 and R9: integer order and lane order
    lw[0] = mk(16); lw[1] = mk(1); lw[2] = mk(2); lw[3] = mk(59); lw[4] = mk(3);
    step(5, 3'b000, 0, "R9");
    for (int i = 0; i < 4; i++) step(0, 3'b010, 0, "R5");
    step(0, 3'b111, 0, "R5");
    step(0, 3'b000, 1, "R5");

    // R8: flush with a full offer and all units ready
    rand_lanes();
    step(8, 3'b000, 0, "R8");
    step(8, 3'b111, 1, "R8");
    step(0, 3'b111, 0, "R8");

    // R6: sweep every offered count at every occupancy
    for (int o = 0; o <= 8; o++) begin
      for (int c = 0; c < 16; c++) begin
        for (int k = 0; k < 8; k++) lw[k] = mk(31);
        step(o, 3'b000, 0, "R6");
        step(c, 3'b000, 0, "R6");
        step(0, 3'b000, 1, "R6");
      end
    end

    // R4/R7: random traffic
    for (int i = 0; i < 4000; i++) begin
      rand_lanes();
      step(int'($urandom % 16), 3'($urandom), ($urandom % 20) == 0,
           (i % 2 == 0) ? "R4" : "R7");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule